// File: doc/BRIEF.md
# Four-Channel Excitation Pulse Generator

The block drives four excitation outputs with square pulses whose timing is counted in cycles of the converter sample clock, which is the clock of the block itself. An internal phase counter sets the length of each pulse cycle. The cycle is 16 clocks at normal speed and 8 clocks at double speed. Each pulse is high for the first half of its cycle and low for the second half. A sequencer decides when pulsing runs. In counted mode a start strobe launches a burst of a programmed number of cycles. In free-run mode pulses repeat for as long as at least one output is enabled.

Two registers hold the setup. The configuration word at offset 0x00 carries the burst length, the speed choice and two free-run switches. The control word at offset 0x10 carries one invert bit and one enable bit for each output, plus a read-only busy flag. Each output can be gated off or inverted on its own. When the phase counter is set to free-run, it keeps turning while the converter is enabled, and a new burst then waits for the next cycle boundary so that it stays aligned to that running phase.

Top module: `exc_pulse_gen`

## Requirements
- R1: After reset both registers read 0, every output is 0 and status is 0.
- R2: Configuration at offset 0x00 holds count in bits 11:0, speed in bit 12 (1 = double), phase free-run in bit 13 and pulse free-run in bit 14. Control at offset 0x10 holds invert bits in 3:0 and enable bits in 7:4 (bit n belongs to output n), and reads status in bit 8. Writes to bit 8 and to unused bits have no effect. Any other offset reads 0.
- R3: In counted mode (pulse free-run 0, phase free-run 0, converter enabled), a start strobe with count C > 0 raises status one clock after the strobe edge. Status then stays high for exactly C full cycles.
- R4: At normal speed a cycle lasts 16 clocks: the output is high for 8 clocks and then low for 8.
- R5: At double speed a cycle lasts 8 clocks: the output is high for 4 clocks and then low for 4.
- R6: An output whose enable bit is 0 holds its idle level for the whole run.
- R7: An output whose invert bit is 1 carries the complement of its waveform. Its idle level is then 1 instead of 0.
- R8: A start strobe with count 0 in counted mode produces no pulses and leaves status at 0.
- R9: With pulse free-run set and the converter enabled, pulsing begins without a strobe and continues past the programmed count. It stops one clock after all four enable bits are cleared.
- R10: Dropping the converter enable stops pulsing on the next edge. Status returns to 0 and the phase counter returns to 0.
- R11: With phase free-run set, the phase counter runs whenever the converter is enabled. A start strobe arms the burst, and the burst begins at the next phase wrap. With phase free-run clear, an idle phase counter rests at 0 and a burst begins on the edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| conv_en | input | 1 | Converter enable |
| start | input | 1 | One-clock burst start strobe |
| pulse_out | output | 4 | Excitation outputs |
| status | output | 1 | High while pulsing is running |

## Verification
The bench checks the last clock of a burst. A sequencer that is off by one in its count would run one cycle too many or stop one cycle short, and the check would see status at the wrong level on that sample. It also switches to double speed, where a design with a fixed 16-clock cycle would keep the outputs high for 8 clocks instead of 4. A mix of enable and invert settings catches an output whose idle level ignores its invert bit. For phase free-run, a strobe is placed in the middle of a phase cycle. A design that started the burst at once, instead of waiting for the wrap, would raise status eleven clocks early.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int N_OUT    = 4;
    localparam int CNT_W    = 12;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int SLOW_LEN = 16;
    localparam int FAST_LEN = 8;
    localparam int PH_W     = $clog2(SLOW_LEN);
    localparam logic [ADDR_W-1:0] CFG_OFS = 8'h00;
    localparam logic [ADDR_W-1:0] CTL_OFS = 8'h10;
    localparam int STATUS_BIT = 2 * N_OUT;

    // Field order equals register bit order (MSB first)
    typedef struct packed {
        logic             pulse_free;
        logic             phase_free;
        logic             fast;
        logic [CNT_W-1:0] count;
    } cfg_t;

    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic [N_OUT-1:0] inv;
    } ctl_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2
    } seq_state_t;

    function automatic logic [PH_W-1:0] cycle_last(input logic fast);
        return fast ? PH_W'(FAST_LEN - 1) : PH_W'(SLOW_LEN - 1);
    endfunction

    function automatic logic [PH_W-1:0] cycle_half(input logic fast);
        return fast ? PH_W'(FAST_LEN / 2) : PH_W'(SLOW_LEN / 2);
    endfunction
endpackage

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output cfg_t          cfg,
    output ctl_t          ctl,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            ctl <= '0;
        end else if (wr) begin
            if (addr == CFG_OFS) cfg <= cfg_t'(wdata[CFG_W-1:0]);
            if (addr == CTL_OFS) ctl <= ctl_t'(wdata[CTL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CFG_OFS) begin
            rdata[CFG_W-1:0] = cfg;
        end else if (addr == CTL_OFS) begin
            rdata[CTL_W-1:0]  = ctl;
            rdata[STATUS_BIT] = busy;
        end
    end
endmodule

// File: rtl/exc_phase.sv
module exc_phase
    import exc_pkg::*;
#(
    parameter int PW = PH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          fast,
    output logic [PW-1:0] ph,
    output logic          wrap,
    output logic          first_half
);
    always_comb begin
        wrap       = run && (ph >= cycle_last(fast));
        first_half = ph < cycle_half(fast);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) ph <= '0;
        else if (wrap)   ph <= '0;
        else             ph <= ph + PW'(1);
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_en,
    input  logic start,
    input  cfg_t cfg,
    input  ctl_t ctl,
    input  logic ph_wrap,
    output logic phase_run,
    output logic active
);
    seq_state_t    st, nxt;
    logic [CW-1:0] remaining;
    logic          run_free;
    logic          load, en_any, start_ok, want, entry_ok;

    always_comb begin
        en_any    = |ctl.en;
        start_ok  = start && !cfg.pulse_free && (cfg.count != '0);
        want      = start_ok || (cfg.pulse_free && en_any);
        entry_ok  = cfg.pulse_free ? en_any : (cfg.count != '0);
        active    = (st == SQ_RUN);
        phase_run = conv_en && (cfg.phase_free || active);
        nxt       = st;
        load      = 1'b0;
        case (st)
            SQ_IDLE: begin
                if (conv_en && want) begin
                    if (cfg.phase_free) begin
                        nxt = SQ_ARMED;
                    end else begin
                        nxt  = SQ_RUN;
                        load = 1'b1;
                    end
                end
            end
            SQ_ARMED: begin
                if (!conv_en || !cfg.phase_free) begin
                    nxt = SQ_IDLE;
                end else if (ph_wrap && entry_ok) begin
                    nxt  = SQ_RUN;
                    load = 1'b1;
                end
            end
            SQ_RUN: begin
                if (!conv_en) begin
                    nxt = SQ_IDLE;
                end else if (run_free) begin
                    if (!cfg.pulse_free || !en_any) nxt = SQ_IDLE;
                end else if (ph_wrap && remaining <= CW'(1)) begin
                    nxt = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            remaining <= '0;
            run_free  <= 1'b0;
        end else begin
            st <= nxt;
            if (load) begin
                remaining <= cfg.count;
                run_free  <= cfg.pulse_free;
            end else if (active && !run_free && ph_wrap && remaining != '0) begin
                remaining <= remaining - CW'(1);
            end
        end
    end
endmodule

// File: rtl/exc_outs.sv
module exc_outs
    import exc_pkg::*;
#(
    parameter int NO = N_OUT
) (
    input  logic          active,
    input  logic          first_half,
    input  logic [NO-1:0] en,
    input  logic [NO-1:0] inv,
    output logic [NO-1:0] pulse
);
    for (genvar i = 0; i < NO; i++) begin : g_ch
        always_comb pulse[i] = (active && en[i] && first_half) ^ inv[i];
    end
endmodule

// File: rtl/exc_pulse_gen.sv
module exc_pulse_gen
    import exc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NO = N_OUT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          conv_en,
    input  logic          start,
    output logic [NO-1:0] pulse_out,
    output logic          status
);
    cfg_t            cfg_q;
    ctl_t            ctl_q;
    logic [PH_W-1:0] ph;
    logic            ph_wrap, first_half, phase_run, active;

    exc_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(active), .cfg(cfg_q), .ctl(ctl_q), .rdata(reg_rdata)
    );

    exc_phase #(.PW(PH_W)) u_phase (
        .clk(clk), .rst(rst), .run(phase_run), .fast(cfg_q.fast),
        .ph(ph), .wrap(ph_wrap), .first_half(first_half)
    );

    exc_seq #(.CW(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .conv_en(conv_en), .start(start),
        .cfg(cfg_q), .ctl(ctl_q), .ph_wrap(ph_wrap),
        .phase_run(phase_run), .active(active)
    );

    exc_outs #(.NO(NO)) u_outs (
        .active(active), .first_half(first_half),
        .en(ctl_q.en), .inv(ctl_q.inv), .pulse(pulse_out)
    );

    assign status = active;
endmodule

// File: rtl/exc_chk.sv
module exc_chk
    import exc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            conv_en,
    input logic            start,
    input logic            status,
    input logic [N_OUT-1:0] pulse_out,
    input cfg_t            cfg,
    input ctl_t            ctl,
    input logic [PH_W-1:0] ph
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !status |-> pulse_out == ctl.inv) else $error("idle level"); // R7
    AST_CONV_OFF: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> !status) else $error("converter off"); // R10
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> ph == '0) else $error("phase hold"); // R11
    AST_START_NEEDED: assert property (@(posedge clk) disable iff (rst)
        ($rose(status) && !$past(cfg.pulse_free) && !$past(cfg.phase_free)) |-> $past(start))
        else $error("burst without strobe"); // R3
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($rose(status) && !$past(cfg.pulse_free)) |-> $past(cfg.count) != '0)
        else $error("zero count burst"); // R8
endmodule

bind exc_pulse_gen exc_chk u_chk (
    .clk(clk), .rst(rst), .conv_en(conv_en), .start(start), .status(status),
    .pulse_out(pulse_out), .cfg(cfg_q), .ctl(ctl_q), .ph(ph)
);

// File: tb/tb_exc_pulse_gen.sv
module tb_exc_pulse_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_en = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  pulse_out;
    logic        status;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_pulse_gen dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_en(conv_en),
        .start(start), .pulse_out(pulse_out), .status(status)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // counted burst, checks every clock of it plus two idle clocks
    task automatic burst(input int cnt, input bit fast, input logic [3:0] en,
                         input logic [3:0] inv, input string req);
        int len = fast ? 8 : 16;
        wr(8'h10, {24'd0, en, inv});
        wr(8'h00, {17'd0, 1'b0, 1'b0, fast, 12'(cnt)});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= len * cnt + 2; k++) begin
            bit       on = (k <= len * cnt);
            bit       hi = on && (((k - 1) % len) < len / 2);
            logic [3:0] e = ({4{hi}} & en) ^ inv;
            chk(status == on, {req, " status"}, 32'(status), 32'(on));
            chk(pulse_out == e, {req, " wave"}, 32'(pulse_out), 32'(e));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(status == 1'b0, "R1 status", 32'(status), 0);
        chk(pulse_out == 4'h0, "R1 outputs", 32'(pulse_out), 0);
        rd_chk(8'h00, 32'h0, "R1 cfg");
        rd_chk(8'h10, 32'h0, "R1 ctl");
    endtask

    task automatic t_regs();
        wr(8'h00, 32'hFFFF_FABC);
        rd_chk(8'h00, 32'h0000_7ABC, "R2 cfg readback");
        wr(8'h10, 32'h0000_01FF);
        rd_chk(8'h10, 32'h0000_00FF, "R2 ctl readback, status read-only");
        rd_chk(8'h04, 32'h0, "R2 unmapped offset");
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_zero_count();
        wr(8'h10, 32'h0000_00F0);
        wr(8'h00, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            chk(status == 1'b0 && pulse_out == 4'h0, "R8 count zero", 32'({status, pulse_out}), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_free_run();
        wr(8'h10, 32'h0000_00F0);
        wr(8'h00, {17'd0, 1'b1, 1'b0, 1'b0, 12'd1}); // j=1 after write edge
        chk(status == 1'b0, "R9 not yet running", 32'(status), 0);
        @(negedge clk);                                // j=2
        for (int k = 0; k < 100; k++) begin
            logic [3:0] e = ((k % 16) < 8) ? 4'hF : 4'h0;
            chk(status == 1'b1, "R9 runs past count", 32'(status), 1);
            chk(pulse_out == e, "R9 wave", 32'(pulse_out), 32'(e));
            @(negedge clk);
        end
        wr(8'h10, 32'h0);
        @(negedge clk);
        chk(status == 1'b0, "R9 stops when all disabled", 32'(status), 0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_conv_off();
        wr(8'h10, 32'h0000_00F3);
        wr(8'h00, 32'd5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(status == 1'b1, "R10 running before drop", 32'(status), 1);
        conv_en = 1'b0;
        @(negedge clk);
        chk(status == 1'b0, "R10 status drops", 32'(status), 0);
        chk(pulse_out == 4'h3, "R10 outputs idle", 32'(pulse_out), 32'h3);
        conv_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(status == 1'b0, "R10 stays idle", 32'(status), 0);
    endtask

    task automatic t_phase_free();
        wr(8'h10, 32'h0000_00F0);
        wr(8'h00, {17'd0, 1'b0, 1'b1, 1'b0, 12'd1}); // j=1
        for (int j = 1; j <= 34; j++) begin
            start = (j == 5);
            if (j == 16) chk(status == 1'b0, "R11 armed waits for wrap", 32'(status), 0);
            if (j == 17) begin
                chk(status == 1'b1, "R11 starts at wrap", 32'(status), 1);
                chk(pulse_out == 4'hF, "R11 first half high", 32'(pulse_out), 32'hF);
            end
            if (j == 33) chk(status == 1'b0, "R11 one cycle done", 32'(status), 0);
            @(negedge clk);
        end
        start = 1'b0;
        wr(8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        conv_en = 1'b1;
        burst(3, 1'b0, 4'hF, 4'h0, "R3 R4 normal");
        burst(2, 1'b1, 4'hF, 4'h0, "R5 double");
        burst(1, 1'b0, 4'b0101, 4'b0011, "R6 R7 enable invert");
        t_zero_count();
        t_free_run();
        t_conv_off();
        t_phase_free();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule